// File: doc/BRIEF.md
# Reference-Locked TDM Clock Synthesizer

This block is a digital phase-locked loop that runs from a single master clock of nominally 20 MHz. It steers a 32-bit phase-accumulator oscillator so that the TDM timing it produces follows one external reference. The reference may be 8 kHz, 2.048 MHz, 8.192 MHz or 19.44 MHz. The timing outputs are a 2.048 MHz clock, an 8.192 MHz clock and an 8 kHz frame pulse. All three come from one tick counter, so they stay aligned with each other at all times.

Reference edges arrive as one-cycle event pulses that are already synchronised to the master clock. A two-bit code names the rate of those edges. A prescaler counts the edges down to one comparison event per 8 kHz frame. At each comparison the position of the synthesized frame is sampled as a signed phase error, and that error drives a proportional-integral filter. Because every rate is compared at the same frame rate and in the same phase units, one set of gains gives the same loop bandwidth (tens of hertz, set by the gain shifts) at every rate.

A fail flag from an external reference monitor forces free-run: the oscillator returns to its nominal word, the integrator is cleared and the lock output drops. When the flag clears, tracking resumes without any other action. A lock flag reports when the phase error has stayed small for a run of comparisons.

Top module: `tdm_sync_dpll`

## Requirements
- R1: While reset is held, the outputs are as follows: `clk8m_o` = 0, `clk2m_o` = 0, `frame_o` = 1 and `lock_o` = 0. At reset the tick counter and the accumulator are zero, and the frequency word is nominal.
- R2: On every master clock cycle, the frequency word is added to a 32-bit accumulator. Each carry out of the accumulator advances an 11-bit tick counter by one. `clk8m_o` is bit 0 of that counter, so it toggles on each tick.
- R3: `clk2m_o` is bit 2 of the tick counter. Each of its transitions coincides with a falling edge of `clk8m_o`.
- R4: `frame_o` is high while counter bits 10..1 are all zero. This makes it two ticks wide (one 8.192 MHz period) once every 2048 ticks. It rises as the counter wraps to zero, together with a falling `clk8m_o` and while `clk2m_o` is low.
- R5: The nominal frequency word is 3518437209. At this word, 2500 master cycles after reset produce exactly 1024 rising edges of `clk8m_o`.
- R6: The rate code on `ref_rate_i` selects how many reference edges make up one comparison: 0 = 8 kHz (1 edge), 1 = 2.048 MHz (256 edges), 2 = 8.192 MHz (1024 edges), 3 = 19.44 MHz (2430 edges). The edge that completes a count raises a comparison event in the next cycle.
- R7: On a comparison event, the phase error is the signed 19-bit value formed from {tick counter, accumulator bits 31..24}. The integrator adds error×4. The new frequency word is nominal − error×128 − integrator. This word takes effect from the following cycle.
- R8: `lock_o` rises after 16 consecutive comparisons whose absolute error is below 512.
- R9: Once locked, `lock_o` falls after 4 consecutive comparisons whose absolute error is 512 or more. Three such comparisons leave it high.
- R10: The cycle after `ref_fail_i` is sampled high, the loop is in free-run. In free-run the frequency word is forced to nominal, the integrator and the lock counts are cleared, `lock_o` is low, and reference edges are ignored with the prescaler held at zero.
- R11: When `ref_fail_i` returns low, comparisons resume from a fresh prescaler count and the loop again follows R6 to R9 without any other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_edge_i | input | 1 | One-cycle pulse per reference edge |
| ref_rate_i | input | 2 | Reference rate code (see R6) |
| ref_fail_i | input | 1 | Reference failure from the monitor |
| clk2m_o | output | 1 | 2.048 MHz clock |
| clk8m_o | output | 1 | 8.192 MHz clock |
| frame_o | output | 1 | 8 kHz frame pulse |
| lock_o | output | 1 | Loop locked |

## Verification
The hardest state to reach from the ports is a loss of lock. It needs a loop that has first met the 16-comparison run, followed by a phase step that stays above threshold for exactly four comparisons. The stimulus reaches it in three steps. First, it spaces 8 kHz edges exactly 2500 cycles apart from the release of reset, so that the first error is zero and lock builds up cleanly. Next, it delays one edge by 50 cycles, which moves the error far beyond the threshold. Finally, it samples the lock output after the third and after the fourth late comparison. Free-run, recovery and the three faster rate codes then follow, and a cycle-level model tracks them on every clock.

// File: rtl/tdm_dpll_pkg.sv
package tdm_dpll_pkg;

    localparam int unsigned FRAME_HZ = 8000;

    typedef enum logic [1:0] {
        RATE_8K    = 2'd0,
        RATE_2M048 = 2'd1,
        RATE_8M192 = 2'd2,
        RATE_19M44 = 2'd3
    } ref_rate_e;

    function automatic int unsigned rate_hz(ref_rate_e r);
        case (r)
            RATE_8K:    return 8000;
            RATE_2M048: return 2048000;
            RATE_8M192: return 8192000;
            default:    return 19440000;
        endcase
    endfunction

    // reference edges that make up one 8 kHz comparison interval
    function automatic int unsigned edges_per_frame(ref_rate_e r);
        return rate_hz(r) / FRAME_HZ;
    endfunction

endpackage

// File: rtl/tdm_ref_prescaler.sv
module tdm_ref_prescaler
    import tdm_dpll_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_edge_i,
    input  logic      clear_i,
    input  ref_rate_e rate_i,
    output logic      evt_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             evt;
    } presc_t;

    presc_t           s_d, s_q;
    logic [DIV_W-1:0] wrap_at;

    always_comb begin
        wrap_at = DIV_W'(edges_per_frame(rate_i) - 1);
        s_d     = s_q;
        s_d.evt = 1'b0;
        if (clear_i) begin
            s_d.cnt = '0;
        end else if (ref_edge_i) begin
            if (s_q.cnt >= wrap_at) begin
                s_d.cnt = '0;
                s_d.evt = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign evt_o = s_q.evt;

    // R6
    evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(ref_edge_i && !clear_i));

endmodule

// File: rtl/tdm_nco_chain.sv
module tdm_nco_chain #(
    parameter int ACC_W  = 32,
    parameter int CNT_W  = 11,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ACC_W-1:0]        ftw_i,
    output logic                    clk8m_o,
    output logic                    clk2m_o,
    output logic                    frame_o,
    output logic [CNT_W+FRAC_W-1:0] phase_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } nco_t;

    nco_t s_d, s_q;
    logic carry;

    always_comb begin
        s_d              = s_q;
        {carry, s_d.acc} = {1'b0, s_q.acc} + {1'b0, ftw_i};
        s_d.cnt          = s_q.cnt + CNT_W'(carry);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign clk8m_o = s_q.cnt[0];
    assign clk2m_o = s_q.cnt[2];
    assign frame_o = (s_q.cnt[CNT_W-1:1] == '0);
    assign phase_o = {s_q.cnt, s_q.acc[ACC_W-1 -: FRAC_W]};

    // R2
    tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk8m_o) |-> $past(carry));

    // R3
    clk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk2m_o) |-> $fell(clk8m_o));

    // R4
    frame_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_o) |-> ($fell(clk8m_o) && !clk2m_o));

endmodule

// File: rtl/tdm_loop_filter.sv
module tdm_loop_filter #(
    parameter int             ACC_W    = 32,
    parameter int             PH_W     = 19,
    parameter int             INT_W    = 40,
    parameter logic [ACC_W-1:0] NOM_FTW = 32'd3518437209,
    parameter int             KP_SH    = 7,
    parameter int             KI_SH    = 2,
    parameter int             LOCK_THR = 512,
    parameter int             LOCK_IN  = 16,
    parameter int             LOCK_OUT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             freerun_i,
    input  logic [PH_W-1:0]  phase_i,
    output logic [ACC_W-1:0] ftw_o,
    output logic             lock_o
);

    localparam int CW = $clog2(LOCK_IN + LOCK_OUT + 1);

    typedef struct packed {
        logic [INT_W-1:0] integ;
        logic [ACC_W-1:0] ftw;
        logic [CW-1:0]    good;
        logic [CW-1:0]    bad;
        logic             lock;
    } lf_t;

    lf_t                     s_d, s_q;
    logic signed [INT_W-1:0] err_x, integ_n, ftw_full;
    logic [PH_W-1:0]         err_mag;
    logic                    near;

    always_comb begin
        err_x    = {{(INT_W-PH_W){phase_i[PH_W-1]}}, phase_i};
        err_mag  = phase_i[PH_W-1] ? (~phase_i + PH_W'(1)) : phase_i;
        near     = (err_mag < PH_W'(LOCK_THR));
        integ_n  = $signed(s_q.integ) + (err_x <<< KI_SH);
        ftw_full = $signed({{(INT_W-ACC_W){1'b0}}, NOM_FTW}) - (err_x <<< KP_SH) - integ_n;

        s_d = s_q;
        if (freerun_i) begin
            s_d     = '0;
            s_d.ftw = NOM_FTW;
        end else if (evt_i) begin
            s_d.integ = integ_n;
            s_d.ftw   = ftw_full[ACC_W-1:0];
            if (near) begin
                s_d.bad = '0;
                if (s_q.good != CW'(LOCK_IN)) s_d.good = s_q.good + CW'(1);
                if (s_d.good == CW'(LOCK_IN)) s_d.lock = 1'b1;
            end else begin
                s_d.good = '0;
                if (s_q.bad != CW'(LOCK_OUT)) s_d.bad = s_q.bad + CW'(1);
                if (s_d.bad == CW'(LOCK_OUT)) s_d.lock = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{integ: '0, ftw: NOM_FTW, good: '0, bad: '0, lock: 1'b0};
        else        s_q <= s_d;
    end

    assign ftw_o  = s_q.ftw;
    assign lock_o = s_q.lock;

    // R10
    freerun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freerun_i |=> (ftw_o == NOM_FTW && !lock_o));

    // R8
    lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_o) |-> $past(evt_i || freerun_i));

    // R9
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> $past(freerun_i || (evt_i && !near)));

endmodule

// File: rtl/tdm_sync_dpll.sv
module tdm_sync_dpll
    import tdm_dpll_pkg::*;
#(
    parameter int               ACC_W    = 32,
    parameter logic [ACC_W-1:0] NOM_FTW  = 32'd3518437209,
    parameter int               CNT_W    = 11,
    parameter int               FRAC_W   = 8,
    parameter int               INT_W    = 40,
    parameter int               KP_SH    = 7,
    parameter int               KI_SH    = 2,
    parameter int               LOCK_THR = 512,
    parameter int               LOCK_IN  = 16,
    parameter int               LOCK_OUT = 4,
    parameter int               DIV_W    = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_edge_i,
    input  logic [1:0] ref_rate_i,
    input  logic       ref_fail_i,
    output logic       clk2m_o,
    output logic       clk8m_o,
    output logic       frame_o,
    output logic       lock_o
);

    localparam int PH_W = CNT_W + FRAC_W;

    typedef struct packed {
        logic freerun;
    } mode_t;

    mode_t            s_d, s_q;
    logic             cmp_evt;
    logic [ACC_W-1:0] ftw;
    logic [PH_W-1:0]  phase;

    always_comb begin
        s_d         = s_q;
        s_d.freerun = ref_fail_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    tdm_ref_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_edge_i (ref_edge_i),
        .clear_i    (ref_fail_i),
        .rate_i     (ref_rate_e'(ref_rate_i)),
        .evt_o      (cmp_evt)
    );

    tdm_loop_filter #(
        .ACC_W    (ACC_W),
        .PH_W     (PH_W),
        .INT_W    (INT_W),
        .NOM_FTW  (NOM_FTW),
        .KP_SH    (KP_SH),
        .KI_SH    (KI_SH),
        .LOCK_THR (LOCK_THR),
        .LOCK_IN  (LOCK_IN),
        .LOCK_OUT (LOCK_OUT)
    ) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (cmp_evt),
        .freerun_i (s_q.freerun),
        .phase_i   (phase),
        .ftw_o     (ftw),
        .lock_o    (lock_o)
    );

    tdm_nco_chain #(
        .ACC_W  (ACC_W),
        .CNT_W  (CNT_W),
        .FRAC_W (FRAC_W)
    ) u_nco (
        .clk     (clk),
        .rst_n   (rst_n),
        .ftw_i   (ftw),
        .clk8m_o (clk8m_o),
        .clk2m_o (clk2m_o),
        .frame_o (frame_o),
        .phase_o (phase)
    );

endmodule

// File: tb/tdm_sync_dpll_tb.sv
module tdm_sync_dpll_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_edge = 1'b0;
    logic       ref_fail = 1'b0;
    logic [1:0] ref_rate = 2'd0;
    logic       clk2m_o, clk8m_o, frame_o, lock_o;

    int    checks = 0;
    int    errors = 0;
    int    rises = 0;
    int    base;
    bit    prev8 = 1'b0;
    string ctx = "R1";

    localparam longint NOM  = 64'd3518437209;
    localparam longint MASK = 64'hFFFFFFFF;

    always #2 clk = ~clk;

    tdm_sync_dpll u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_edge_i (ref_edge),
        .ref_rate_i (ref_rate),
        .ref_fail_i (ref_fail),
        .clk2m_o    (clk2m_o),
        .clk8m_o    (clk8m_o),
        .frame_o    (frame_o),
        .lock_o     (lock_o)
    );

    // behavioural model state
    longint m_acc, m_ftw, m_integ, ph, mag, sum;
    int     m_cnt, m_presc, m_good, m_bad;
    bit     m_evt, m_fr, m_lock;
    longint o_acc;
    int     o_cnt;
    bit     o_evt, o_fr;

    function automatic int div_of(logic [1:0] r);
        case (r)
            2'd0: return 1;
            2'd1: return 256;
            2'd2: return 1024;
            default: return 2430;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_cnt = 0; m_presc = 0; m_evt = 0; m_fr = 0;
            m_ftw = NOM; m_integ = 0; m_good = 0; m_bad = 0; m_lock = 0;
        end else begin
            o_acc = m_acc; o_cnt = m_cnt; o_evt = m_evt; o_fr = m_fr;
            sum   = m_acc + m_ftw;
            m_acc = sum & MASK;
            m_cnt = (m_cnt + int'(sum >> 32)) % 2048;
            m_evt = 0;
            if (ref_fail) m_presc = 0;
            else if (ref_edge) begin
                if (m_presc >= div_of(ref_rate) - 1) begin
                    m_presc = 0; m_evt = 1;
                end else m_presc++;
            end
            m_fr = ref_fail;
            if (o_fr) begin
                m_ftw = NOM; m_integ = 0; m_good = 0; m_bad = 0; m_lock = 0;
            end else if (o_evt) begin
                ph = longint'(o_cnt) * 256 + (o_acc >> 24);
                if (ph >= 262144) ph = ph - 524288;
                mag = (ph < 0) ? -ph : ph;
                m_integ = m_integ + ph * 4;
                m_ftw = (NOM - ph * 128 - m_integ) & MASK;
                if (mag < 512) begin
                    m_bad = 0;
                    if (m_good < 16) m_good++;
                    if (m_good == 16) m_lock = 1;
                end else begin
                    m_good = 0;
                    if (m_bad < 4) m_bad++;
                    if (m_bad == 4) m_lock = 0;
                end
            end
        end
    end

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (phase %s) at %0t: actual=%0d expected=%0d", req, ctx, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (clk8m_o && !prev8) rises++;
        prev8 = clk8m_o;
        if (rst_n) begin
            check(clk8m_o == m_cnt[0], "R2 clk8m", clk8m_o, m_cnt[0]);
            check(clk2m_o == m_cnt[2], "R3 clk2m", clk2m_o, m_cnt[2]);
            check(frame_o == ((m_cnt >> 1) == 0), "R4 frame", frame_o, ((m_cnt >> 1) == 0));
            check(lock_o == m_lock, "R8 R9 lock", lock_o, m_lock);
        end
    end

    task automatic send_edges(int n, int gap);
        for (int i = 0; i < n; i++) begin
            repeat (gap - 1) @(negedge clk);
            ref_edge = 1'b1;
            @(negedge clk);
            ref_edge = 1'b0;
        end
    endtask

    task automatic send_burst(int n);
        ref_edge = 1'b1;
        repeat (n) @(negedge clk);
        ref_edge = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog (phase %s): actual=hung expected=done", ctx);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        #1;
        // R1 reset state
        check(clk8m_o == 1'b0, "R1 clk8m reset", clk8m_o, 0);
        check(clk2m_o == 1'b0, "R1 clk2m reset", clk2m_o, 0);
        check(frame_o == 1'b1, "R1 frame reset", frame_o, 1);
        check(lock_o == 1'b0,  "R1 lock reset",  lock_o, 0);

        @(negedge clk);
        rst_n = 1'b1;
        ctx   = "R5";
        base  = rises;
        send_edges(1, 2500);
        #1;
        // R5 nominal word gives 1024 rises in 2500 cycles
        check((rises - base) == 1024, "R5 nominal rises", rises - base, 1024);

        ctx = "R8";
        send_edges(16, 2500);
        repeat (3) @(negedge clk);
        #1;
        check(lock_o == 1'b1, "R8 lock after run", lock_o, 1);
        send_edges(1, 2497);

        ctx = "R9";
        send_edges(1, 2550);
        send_edges(2, 2500);
        repeat (3) @(negedge clk);
        #1;
        check(lock_o == 1'b1, "R9 three late compares keep lock", lock_o, 1);
        send_edges(1, 2497);
        repeat (3) @(negedge clk);
        #1;
        check(lock_o == 1'b0, "R9 fourth late compare drops lock", lock_o, 0);

        ctx = "R10";
        ref_fail = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(lock_o == 1'b0, "R10 lock low in free-run", lock_o, 0);
        base = rises;
        send_edges(1, 2500);
        #1;
        check((rises - base) >= 1023 && (rises - base) <= 1025,
              "R10 nominal rate in free-run", rises - base, 1024);

        ctx = "R11";
        ref_fail = 1'b0;
        send_edges(6, 2500);

        ctx = "R6 R7";
        ref_rate = 2'd1;
        send_edges(800, 10);
        ref_rate = 2'd2;
        send_edges(4000, 2);
        ref_rate = 2'd3;
        send_burst(8000);
        repeat (10) @(negedge clk);
        #1;
        finish_run();
    end

endmodule